// File: doc/BRIEF.md
# Reset-Cause Recorder and Reset-Pin Mode Controller

This block keeps a record of which internal event caused the most recent chip reset, and it decides whether the external reset pin acts as a reset or as a plain input. Each internal reset request line sets its own sticky flag in a status register. Software reads that register after the reset is released. Power-on reset sets no flag. Power-on reset clears the whole register, and so does an external reset through the pin. Internal resets leave the register as it is.

Two controls are protected: clearing the status flags, and switching the pin between its reset role and its input role. Software first writes the wanted value into a staging register. The value takes effect only when software then writes the key byte that belongs to that control, and only while the clock is in normal mode with gear select 00. The block merges power-on, the pin reset and the internal requests into one active-low chip reset. When the pin serves as an input, its synchronized level appears on a port-input output.

Top module: `rst_cause_keeper`

## Requirements
- R1: On a clock edge where internal request line i is high, status bit i becomes 1 and stays 1 until it is cleared. Line 0 is the flash-access-in-standby request. When several lines are high in the same cycle, all of their bits are set.
- R2: While `por_n` is low, the following hold:
  - `chip_rst_n` is 0.
  - After the first edge, the status register, both staged bits and the active pin-disable bit are all 0.
  - `port_in` is 1.
- R3: While the pin is enabled as a reset, a low level on `ext_rst_pin_n` drives `chip_rst_n` low after two clock edges, through the synchronizer. On the following edge the status register clears to 0, even if a request arrives at the same time. The active pin-disable bit is left unchanged.
- R4: A high internal request drives `chip_rst_n` low in the same cycle. An internal request never clears flags that are already set.
- R5: The clear sequence works as follows:
  - Write 1 to staging bit 0 (address 1).
  - Then write key 0x71 to address 2.
  - On that edge the status register clears to 0 and staging bit 0 returns to 0.
- R6: Write 1 to staging bit 1, then write key 0xB2. The active pin-disable bit (address 3, bit 0) becomes 1. After that, a low pin no longer resets the chip, and `port_in` follows the pin two edges after the pin changes.
- R7: Write 0 to staging bit 1, then write key 0xB2. The active pin-disable bit becomes 0 and the pin acts as a reset again.
- R8: A key write takes effect only when `mode_normal` is 1 and `gear_sel` is 00. Otherwise it changes no register.
- R9: The following key writes change nothing, and the staged bits keep their values:
  - any key value other than 0x71 or 0xB2;
  - key 0x71 while staging bit 0 is 0.
- R10: If a request arrives on the edge where a 0x71 commit clears the register, that request's flag is set and all other flags end up 0.
- R11: Reads are combinational.
  - Address 0 returns the status flags in the low bits.
  - Address 1 returns the staged bits (bit 0 is clear, bit 1 is disable).
  - Address 3 returns the active pin-disable bit in bit 0.
  - Address 2 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| int_rst_req | input | N_SRC | Internal reset requests, one per source |
| ext_rst_pin_n | input | 1 | External reset pin, asynchronous, active low |
| mode_normal | input | 1 | 1 when the clock is in normal operating mode |
| gear_sel | input | 2 | Clock gear select; 00 means fc/4 |
| chip_rst_n | output | 1 | Combined chip reset, active low |
| port_in | output | 1 | Synchronized pin level when the pin is disabled as a reset, else 1 |

## Verification
Register writes, key commits and request flags become visible on the edge after the stimulus. The bench drives each stimulus after a falling edge, lets one rising edge pass, and reads back at the next falling edge. `chip_rst_n` follows an internal request in the same cycle, so the bench checks it while the request is still held. Pin effects take two edges to pass the synchronizer, and the clearing of the status register takes a third edge. The directed pin tests therefore count exactly two or three edges before they sample. Random cycles compare every register against a bench model that is updated once per edge.

// File: rtl/rck_pkg.sv
// Package: register addresses, key bytes and bus width shared by the
// reset-cause keeper modules. Assumes a 2-bit register address space.
package rck_pkg;
    localparam int          DW          = 8;
    localparam logic [1:0]  ADDR_STATUS = 2'd0;
    localparam logic [1:0]  ADDR_STAGE  = 2'd1;
    localparam logic [1:0]  ADDR_KEY    = 2'd2;
    localparam logic [1:0]  ADDR_ACTIVE = 2'd3;
    localparam logic [7:0]  KEY_CLEAR   = 8'h71;
    localparam logic [7:0]  KEY_PINMODE = 8'hB2;
    localparam logic [1:0]  GEAR_FC4    = 2'b00;
endpackage

// File: rtl/rck_sync.sv
// Module: multi-flop synchronizer for the asynchronous reset pin.
// Assumes the pin idles high; power-on reset presets every stage to 1
// so that no spurious pin reset appears after power-up.
module rck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!por_n) stage_q <= '1;
        else        stage_q <= {stage_q[STAGES-2:0], din};
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rck_cause_reg.sv
// Module: sticky reset-cause flags. One bit per internal request.
// The flags are cleared by power-on, by an active pin reset, or by a
// committed software clear. A request on the same edge as a software
// clear still leaves its own flag set.
module rck_cause_reg #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_rst,
    input  logic             sw_clear,
    input  logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] flags
);
    logic [N_SRC-1:0] kept;

    // Keep the old flags unless a software clear is being committed.
    always_comb kept = sw_clear ? '0 : flags;

    // Update the flag register.
    always_ff @(posedge clk) begin
        if (!por_n)       flags <= '0;
        else if (pin_rst) flags <= '0;
        else              flags <= kept | req;
    end
endmodule

// File: rtl/rck_key_ctrl.sv
// Module: staged control bits and their keyed commit.
// Assumes single-cycle bus writes. A key write is honoured only in
// normal mode with gear fc/4. The clear stage bit drops after its commit.
module rck_key_ctrl
    import rck_pkg::*;
(
    input  logic          clk,
    input  logic          por_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          mode_normal,
    input  logic [1:0]    gear_sel,
    output logic          stage_clr,
    output logic          stage_dis,
    output logic          active_dis,
    output logic          clear_commit
);
    logic key_ok;
    logic key_wr;
    logic dis_commit;

    // Decode which key, if any, is accepted in this cycle.
    always_comb begin
        key_ok       = mode_normal && (gear_sel == GEAR_FC4);
        key_wr       = bus_we && (bus_addr == ADDR_KEY) && key_ok;
        clear_commit = key_wr && (bus_wdata == KEY_CLEAR) && stage_clr;
        dis_commit   = key_wr && (bus_wdata == KEY_PINMODE);
    end

    // Staging register: written by software, clear bit self-clears on commit.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            stage_clr <= 1'b0;
            stage_dis <= 1'b0;
        end else if (bus_we && (bus_addr == ADDR_STAGE)) begin
            stage_clr <= bus_wdata[0];
            stage_dis <= bus_wdata[1];
        end else if (clear_commit) begin
            stage_clr <= 1'b0;
        end
    end

    // Active pin mode: loaded from the staged bit on a valid pin-mode key.
    always_ff @(posedge clk) begin
        if (!por_n)          active_dis <= 1'b0;
        else if (dis_commit) active_dis <= stage_dis;
    end
endmodule

// File: rtl/rst_cause_keeper.sv
// Module: top of the reset-cause keeper. It records internal reset
// causes, manages the pin mode under keyed commits and merges all
// reset sources into one chip reset. Assumes N_SRC <= bus width.
module rst_cause_keeper
    import rck_pkg::*;
#(
    parameter int N_SRC       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [N_SRC-1:0] int_rst_req,
    input  logic             ext_rst_pin_n,
    input  logic             mode_normal,
    input  logic [1:0]       gear_sel,
    output logic             chip_rst_n,
    output logic             port_in
);
    logic             pin_sync;
    logic             pin_rst;
    logic             stage_clr;
    logic             stage_dis;
    logic             active_dis;
    logic             clear_commit;
    logic [N_SRC-1:0] flags;

    rck_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (ext_rst_pin_n),
        .dout  (pin_sync)
    );

    rck_key_ctrl u_key (
        .clk          (clk),
        .por_n        (por_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .mode_normal  (mode_normal),
        .gear_sel     (gear_sel),
        .stage_clr    (stage_clr),
        .stage_dis    (stage_dis),
        .active_dis   (active_dis),
        .clear_commit (clear_commit)
    );

    rck_cause_reg #(.N_SRC(N_SRC)) u_cause (
        .clk      (clk),
        .por_n    (por_n),
        .pin_rst  (pin_rst),
        .sw_clear (clear_commit),
        .req      (int_rst_req),
        .flags    (flags)
    );

    // Pin reset and port value from the synchronized pin and the active mode.
    always_comb begin
        pin_rst = !active_dis && !pin_sync;
        port_in = active_dis ? pin_sync : 1'b1;
    end

    // Merge every reset source into the chip reset.
    always_comb chip_rst_n = por_n && !pin_rst && !(|int_rst_req);

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_STATUS: bus_rdata[N_SRC-1:0] = flags;
            ADDR_STAGE:  bus_rdata[1:0]       = {stage_dis, stage_clr};
            ADDR_ACTIVE: bus_rdata[0]         = active_dis;
            default:     bus_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/rst_cause_keeper_chk.sv
// Checker: temporal properties of the reset-cause keeper, attached by bind.
// Assumes the bound instance exposes flags, stage_clr, active_dis and pin_sync.
module rst_cause_keeper_chk #(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             por_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [N_SRC-1:0] int_rst_req,
    input logic             mode_normal,
    input logic [1:0]       gear_sel,
    input logic             chip_rst_n,
    input logic [N_SRC-1:0] flags,
    input logic             stage_clr,
    input logic             active_dis,
    input logic             pin_sync
);
    // R1: every request line that is high leaves its flag set.
    p_req_sets_flag_r1: assert property (@(posedge clk) disable iff (!por_n)
        (|int_rst_req) |=> ((flags & $past(int_rst_req)) == $past(int_rst_req)));

    // R3: an enabled pin held low pulls the chip reset low.
    p_pin_resets_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!active_dis && !pin_sync) |-> !chip_rst_n);

    // R3: an enabled pin reset clears the flags on the next edge.
    p_pin_clears_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!active_dis && !pin_sync) |=> (flags == '0));

    // R5: a valid clear commit with no request empties flags and stage bit.
    p_key_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
        (bus_we && bus_addr == 2'd2 && bus_wdata == 8'h71 && mode_normal &&
         gear_sel == 2'b00 && stage_clr && int_rst_req == '0)
        |=> (flags == '0 && !stage_clr));

    // R8: a key write outside the allowed clock mode keeps the pin mode.
    p_bad_mode_r8: assert property (@(posedge clk) disable iff (!por_n)
        (bus_we && bus_addr == 2'd2 && !(mode_normal && gear_sel == 2'b00))
        |=> $stable(active_dis));

    // R4: any internal request holds the chip in reset.
    p_req_resets_r4: assert property (@(posedge clk) disable iff (!por_n)
        (|int_rst_req) |-> !chip_rst_n);
endmodule

bind rst_cause_keeper rst_cause_keeper_chk #(.N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .int_rst_req (int_rst_req),
    .mode_normal (mode_normal),
    .gear_sel    (gear_sel),
    .chip_rst_n  (chip_rst_n),
    .flags       (flags),
    .stage_clr   (stage_clr),
    .active_dis  (active_dis),
    .pin_sync    (pin_sync)
);

// File: tb/rst_cause_keeper_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random bus and request traffic,
// checked against a register model kept in the bench.
module rst_cause_keeper_tb;
    localparam int N_SRC = 4;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             bus_we = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [7:0]       bus_wdata = 8'd0;
    logic [7:0]       bus_rdata;
    logic [N_SRC-1:0] int_rst_req = '0;
    logic             ext_rst_pin_n = 1'b1;
    logic             mode_normal = 1'b1;
    logic [1:0]       gear_sel = 2'b00;
    logic             chip_rst_n;
    logic             port_in;

    int checks = 0;
    int errors = 0;

    logic [N_SRC-1:0] m_flags;
    logic             m_sclr, m_sdis, m_adis;

    always #2 clk = ~clk;

    rst_cause_keeper #(.N_SRC(N_SRC)) u_dut (
        .clk(clk), .por_n(por_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_rst_req(int_rst_req),
        .ext_rst_pin_n(ext_rst_pin_n), .mode_normal(mode_normal),
        .gear_sel(gear_sel), .chip_rst_n(chip_rst_n), .port_in(port_in)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Model of one clock edge, written from the requirements.
    task automatic model_edge();
        logic ok;
        ok = mode_normal && gear_sel == 2'b00;
        if (bus_we && bus_addr == 2'd1) begin
            m_sclr = bus_wdata[0];
            m_sdis = bus_wdata[1];
        end
        if (bus_we && bus_addr == 2'd2 && ok) begin
            if (bus_wdata == 8'h71 && m_sclr) begin
                m_flags = '0;
                m_sclr  = 1'b0;
            end
            if (bus_wdata == 8'hB2) m_adis = m_sdis;
        end
        m_flags = m_flags | int_rst_req;
    endtask

    // Apply the current inputs across one edge; return at the falling edge.
    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        bus_we = 1'b0; int_rst_req = '0;
    endtask

    function automatic logic [7:0] rd(input logic [1:0] a);
        bus_addr = a;
        return 8'h00;
    endfunction

    task automatic read_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_we = 1'b0; bus_addr = a; #0.1;
        check(req, bus_rdata, exp);
    endtask

    task automatic check_model(input string req);
        read_chk(req, 2'd0, {{(8-N_SRC){1'b0}}, m_flags});
        read_chk(req, 2'd1, {6'd0, m_sdis, m_sclr});
        read_chk(req, 2'd3, {7'd0, m_adis});
        read_chk(req, 2'd2, 8'h00);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        int_rst_req = '0; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_flags = '0; m_sclr = 1'b0; m_sdis = 1'b0; m_adis = 1'b0;
        @(negedge clk); @(posedge clk); @(negedge clk);
        // R2: reset state while por_n is low
        check("R2 chip_rst_n", {7'd0, chip_rst_n}, 8'h00);
        check("R2 port_in", {7'd0, port_in}, 8'h01);
        check_model("R2 regs");
        por_n = 1'b1;
        @(negedge clk);

        // R1: several sources at once, line 0 is flash-standby access
        int_rst_req = 4'b0101; #0.1;
        check("R4 chip_rst_n during request", {7'd0, chip_rst_n}, 8'h00);
        step(); idle();
        check_model("R1 multi");
        int_rst_req = 4'b1000; step(); idle();
        check_model("R4 request keeps older flags");

        // R8: clear key in wrong gear ignored
        wr(2'd1, 8'h01);
        gear_sel = 2'b01; wr(2'd2, 8'h71); gear_sel = 2'b00;
        check_model("R8 wrong gear");
        mode_normal = 1'b0; wr(2'd2, 8'h71); mode_normal = 1'b1;
        check_model("R8 not normal");
        // R9: wrong key value
        wr(2'd2, 8'h5A);
        check_model("R9 bad key");
        // R5: proper clear
        wr(2'd2, 8'h71);
        check_model("R5 clear");
        // R9: clear key with stage bit already 0
        int_rst_req = 4'b0010; step(); idle();
        wr(2'd2, 8'h71);
        check_model("R9 no pending clear");
        // R10: request on commit edge
        wr(2'd1, 8'h01);
        bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h71; int_rst_req = 4'b0100;
        step(); idle();
        check_model("R10 request wins");
        check("R10 flags", {4'd0, m_flags}, 8'h04);

        // R3: pin reset while enabled
        ext_rst_pin_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R3 one edge", {7'd0, chip_rst_n}, 8'h01);
        @(posedge clk); @(negedge clk);
        check("R3 two edges", {7'd0, chip_rst_n}, 8'h00);
        @(posedge clk); @(negedge clk);
        m_flags = '0;
        check_model("R3 flags cleared");
        ext_rst_pin_n = 1'b1;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        check("R3 released", {7'd0, chip_rst_n}, 8'h01);

        // R6: disable pin reset, pin becomes a port
        wr(2'd1, 8'h02); wr(2'd2, 8'hB2);
        check_model("R6 active");
        int_rst_req = 4'b0001; step(); idle();
        ext_rst_pin_n = 1'b0;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        check("R6 no reset", {7'd0, chip_rst_n}, 8'h01);
        check("R6 port low", {7'd0, port_in}, 8'h00);
        repeat (2) begin @(posedge clk); @(negedge clk); end
        check_model("R6 flags kept");
        ext_rst_pin_n = 1'b1;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        check("R6 port high", {7'd0, port_in}, 8'h01);
        // R7: re-enable
        wr(2'd1, 8'h00); wr(2'd2, 8'hB2);
        check_model("R7 re-enabled");
        check("R7 port idle", {7'd0, port_in}, 8'h01);

        // R11 and all others: seeded random traffic, pin held high
        void'($urandom(32'h1234));
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 5);
            int_rst_req = ($urandom_range(0, 3) == 0) ? N_SRC'($urandom) : '0;
            mode_normal = ($urandom_range(0, 4) != 0);
            gear_sel    = ($urandom_range(0, 4) != 0) ? 2'b00 : 2'($urandom);
            bus_we = (op < 4);
            bus_addr = (op < 2) ? 2'd1 : 2'd2;
            case (op)
                0, 1: bus_wdata = 8'($urandom);
                2: bus_wdata = ($urandom_range(0, 1) != 0) ? 8'h71 : 8'hB2;
                default: bus_wdata = 8'($urandom);
            endcase
            #0.1;
            check("R4 random chip_rst_n", {7'd0, chip_rst_n}, {7'd0, ~(|int_rst_req)});
            step(); idle();
            mode_normal = 1'b1; gear_sel = 2'b00;
            check_model("R11 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule